// File: doc/BRIEF.md
# Serial Frame Receiver with Error Flags

This block recovers characters from an asynchronous serial line that rests high and marks a start bit by going low. An external divider supplies a clock-enable pulse at sixteen times the bit rate. The receiver uses that pulse to confirm the start bit, take one sample near the centre of each later bit, and put the character back together. Software-style configuration inputs select the frame format while the block runs: the word length, whether a parity bit is present, the parity sense, and whether the frame has one or two stop bits.

Each character appears on the output bus together with a one-clock valid pulse. A parity mismatch and a low stop bit are reported as one-clock flags in the same cycle as that valid pulse. A line held low through the whole frame is reported as a break. A break pulse has no valid pulse with it, and after a break the receiver waits for the line to go high again before it looks for a new start bit.

When handshake is enabled and the consumer downstream reports that it is full, the receiver raises its active-low request-to-send output so that the far transmitter pauses. Character storage is left to the consumer.

Top module: `uart_frame_rx`

## Requirements
- R1: While rst_n is low at a clock edge, every pulse output goes low, rx_data clears to zero and rts_n goes low.
- R2: A start bit is taken when the synchronised line is seen low on a tick. If the line is high again 8 ticks later, the receiver returns to idle and produces no output.
- R3: Data bits are sampled every 16 ticks, least significant bit first. The word length is cfg_bits + 1 (0 means 1 bit, 7 means 8 bits). The character appears on rx_data right-aligned with its upper bits zero, in the clock cycle where rx_valid pulses.
- R4: When cfg_par_en is 1, one parity bit follows the data bits. With cfg_par_even = 1 the data bits and the parity bit together must hold an even number of ones, and with cfg_par_even = 0 an odd number. A mismatch pulses rx_parity_err in the same cycle as rx_valid.
- R5: cfg_two_stop = 1 selects two stop bits and 0 selects one. A low stop bit in a frame that is not a break pulses rx_frame_err with rx_valid, and the character is still delivered.
- R6: If every data bit, the parity bit (when enabled) and the first stop bit sample low, the receiver pulses rx_break without rx_valid. It then accepts no start bit until the line has sampled high.
- R7: rts_n is 1 in the cycle after a clock edge at which both cfg_hs_en and sink_full are 1. Otherwise it is 0.
- R8: The receiver's state advances only on clock edges where tick is 1. At any other edge rx_data holds its value and no pulse is raised.
- R9: rx_valid, rx_break, rx_frame_err and rx_parity_err each last exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Clock enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_bits | input | 3 | Word length minus one |
| cfg_par_en | input | 1 | A parity bit is present in each frame |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_hs_en | input | 1 | Enables the handshake output |
| sink_full | input | 1 | The downstream consumer cannot accept more characters |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle pulse: a character is ready |
| rx_frame_err | output | 1 | One-cycle pulse: a stop bit sampled low |
| rx_parity_err | output | 1 | One-cycle pulse: the parity check failed |
| rx_break | output | 1 | One-cycle pulse: break detected |
| rts_n | output | 1 | Active-low request to send |

## Verification
The hardest cases to reach are the ones that depend on where the sample falls inside a bit. Examples are a short low glitch that must be rejected at the start-bit check, and a stop bit that is held low and then released part of the way through. In the second case the receiver can mistake the rest of that low stop bit for a new start bit and must then reject it. The bench gets there by driving whole frames with forced parity and stop faults, a short glitch, and a full-frame break, and by repeating frames with the tick running at one third of the clock rate. A behavioural model tracks the tick count from each start detection, and its outputs are compared with the design's outputs on every clock.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial frame receiver.
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2,
        RX_BRKWAIT
    } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
// Line synchroniser: brings the asynchronous serial input into the clock
// domain through a chain of flops. Assumes the line rests high, so the
// stages reset to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
// Frame engine: confirms the start bit at mid-bit, samples data, parity and
// stop bits once every OVS ticks, and emits one-cycle result pulses.
// Assumes the configuration inputs stay stable while a frame is received.
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      rx_s,
    input  logic [$clog2(DATA_W)-1:0] cfg_bits,
    input  logic                      cfg_par_en,
    input  logic                      cfg_par_even,
    input  logic                      cfg_two_stop,
    output logic [DATA_W-1:0]         data_o,
    output logic                      valid_o,
    output logic                      fe_o,
    output logic                      pe_o,
    output logic                      brk_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              stop1_low;
    logic              bit_pt;
    logic              par_fail;
    logic              all_low;

    assign bit_pt   = (cnt == BIT_LAST);
    // Parity fails when the count of ones does not match the selected sense.
    assign par_fail = cfg_par_en & ((^shreg) ^ par_bit ^ ~cfg_par_even);
    // Break: data, parity (when present) and the current stop sample all low.
    assign all_low  = (shreg == '0) & ~(cfg_par_en & par_bit) & ~rx_s;

    // Frame sequencing, bit capture and result pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            stop1_low <= 1'b0;
            data_o    <= '0;
            valid_o   <= 1'b0;
            fe_o      <= 1'b0;
            pe_o      <= 1'b0;
            brk_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            fe_o    <= 1'b0;
            pe_o    <= 1'b0;
            brk_o   <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == MID_LAST) begin
                            if (rx_s) begin
                                state <= RX_IDLE;
                            end else begin
                                state   <= RX_DATA;
                                cnt     <= '0;
                                idx     <= '0;
                                shreg   <= '0;
                                par_bit <= 1'b0;
                            end
                        end
                    end
                    RX_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (bit_pt) begin
                            cnt        <= '0;
                            shreg[idx] <= rx_s;
                            if (idx == cfg_bits)
                                state <= cfg_par_en ? RX_PARITY : RX_STOP1;
                            else
                                idx <= idx + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        cnt <= cnt + 1'b1;
                        if (bit_pt) begin
                            cnt     <= '0;
                            par_bit <= rx_s;
                            state   <= RX_STOP1;
                        end
                    end
                    RX_STOP1: begin
                        cnt <= cnt + 1'b1;
                        if (bit_pt) begin
                            cnt <= '0;
                            if (all_low) begin
                                brk_o <= 1'b1;
                                state <= RX_BRKWAIT;
                            end else if (cfg_two_stop) begin
                                stop1_low <= ~rx_s;
                                state     <= RX_STOP2;
                            end else begin
                                valid_o <= 1'b1;
                                data_o  <= shreg;
                                pe_o    <= par_fail;
                                fe_o    <= ~rx_s;
                                state   <= RX_IDLE;
                            end
                        end
                    end
                    RX_STOP2: begin
                        cnt <= cnt + 1'b1;
                        if (bit_pt) begin
                            cnt     <= '0;
                            valid_o <= 1'b1;
                            data_o  <= shreg;
                            pe_o    <= par_fail;
                            fe_o    <= stop1_low | ~rx_s;
                            state   <= RX_IDLE;
                        end
                    end
                    RX_BRKWAIT: begin
                        if (rx_s) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_flow.sv
// Handshake driver: raises the active-low request-to-send output one cycle
// after handshake is enabled and the consumer reports that it is full.
module uart_rx_flow (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_en,
    input  logic full,
    output logic rts_n
);
    // Register the pause request.
    always_ff @(posedge clk) begin
        if (!rst_n) rts_n <= 1'b0;
        else        rts_n <= hs_en & full;
    end
endmodule

// File: rtl/uart_frame_rx.sv
// Serial frame receiver top: synchroniser, frame engine and handshake.
// Assumes tick pulses for one clock at OVS times the bit rate.
module uart_frame_rx #(
    parameter int DATA_W    = 8,
    parameter int OVS       = 16,
    parameter int SYNC_FLOP = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      rxd,
    input  logic [$clog2(DATA_W)-1:0] cfg_bits,
    input  logic                      cfg_par_en,
    input  logic                      cfg_par_even,
    input  logic                      cfg_two_stop,
    input  logic                      cfg_hs_en,
    input  logic                      sink_full,
    output logic [DATA_W-1:0]         rx_data,
    output logic                      rx_valid,
    output logic                      rx_frame_err,
    output logic                      rx_parity_err,
    output logic                      rx_break,
    output logic                      rts_n
);
    logic rx_s;

    uart_rx_sync #(.STAGES(SYNC_FLOP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s)
    );

    uart_rx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .rx_s         (rx_s),
        .cfg_bits     (cfg_bits),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .cfg_two_stop (cfg_two_stop),
        .data_o       (rx_data),
        .valid_o      (rx_valid),
        .fe_o         (rx_frame_err),
        .pe_o         (rx_parity_err),
        .brk_o        (rx_break)
    );

    uart_rx_flow u_flow (
        .clk   (clk),
        .rst_n (rst_n),
        .hs_en (cfg_hs_en),
        .full  (sink_full),
        .rts_n (rts_n)
    );
endmodule

// File: rtl/uart_frame_rx_chk.sv
// Property checker for the serial frame receiver, attached by bind.
module uart_frame_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              cfg_hs_en,
    input logic              sink_full,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_frame_err,
    input logic              rx_parity_err,
    input logic              rx_break,
    input logic              rts_n
);
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r9_break_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> !rx_break);
    a_r6_break_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |-> !rx_valid);
    a_r5_fe_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> rx_valid);
    a_r4_pe_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_parity_err |-> rx_valid);
    a_r7_rts_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hs_en && sink_full) |=> rts_n);
    a_r7_rts_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_hs_en && sink_full) |=> !rts_n);
    a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(rx_data));
    a_r8_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !(rx_valid || rx_break));
endmodule

bind uart_frame_rx uart_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .cfg_hs_en     (cfg_hs_en),
    .sink_full     (sink_full),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_frame_err  (rx_frame_err),
    .rx_parity_err (rx_parity_err),
    .rx_break      (rx_break),
    .rts_n         (rts_n)
);

// File: tb/uart_frame_rx_test.sv
module uart_frame_rx_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] cfg_bits = 3'd7;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_hs_en = 1'b0;
    logic       sink_full = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_frame_err, rx_parity_err, rx_break, rts_n;

    int checks = 0;
    int errors = 0;
    int div = 1;
    int tcnt = 0;
    bit run_cmp = 0;
    bit done = 0;
    int n_valid = 0, n_brk = 0, n_fe = 0, n_pe = 0;

    uart_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
        .cfg_hs_en(cfg_hs_en), .sink_full(sink_full),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .rx_break(rx_break), .rts_n(rts_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Tick generator: one pulse every div clocks.
    initial begin
        forever begin
            @(negedge clk);
            if (tcnt >= div - 1) begin tick = 1'b1; tcnt = 0; end
            else begin tick = 1'b0; tcnt++; end
        end
    end

    // Behavioural reference model.
    int   m_mode = 0;
    int   m_t = 0;
    bit   m_s1 = 1, m_s2 = 1;
    bit   smp[$];
    logic       e_valid = 0, e_fe = 0, e_pe = 0, e_brk = 0, e_rts = 0;
    logic [7:0] e_data = 0;

    always @(posedge clk) begin
        bit s;
        int nb, np, k, ones;
        bit allz, anystop0;
        s = m_s2;
        e_valid = 0; e_fe = 0; e_pe = 0; e_brk = 0;
        if (!rst_n) begin
            m_mode = 0; m_s1 = 1; m_s2 = 1; e_data = 0; e_rts = 0;
        end else begin
            e_rts = cfg_hs_en && sink_full;
            if (tick) begin
                if (m_mode == 0) begin
                    if (!s) begin m_mode = 1; m_t = 0; smp.delete(); end
                end else if (m_mode == 2) begin
                    if (s) m_mode = 0;
                end else begin
                    m_t++;
                    if (m_t == 8 && s) m_mode = 0;
                    else if (m_t > 8 && (m_t - 8) % 16 == 0) begin
                        smp.push_back(s);
                        k  = smp.size();
                        nb = int'(cfg_bits) + 1;
                        np = cfg_par_en ? 1 : 0;
                        allz = 1;
                        for (int i = 0; i < k; i++) if (smp[i]) allz = 0;
                        if ((k == nb + np + 1 && allz)) begin
                            e_brk = 1; m_mode = 2;
                        end else if ((k == nb + np + 1 && !cfg_two_stop) || k == nb + np + 2) begin
                            e_valid = 1; e_data = 0; ones = 0; anystop0 = 0;
                            for (int i = 0; i < nb; i++) begin
                                e_data[i] = smp[i];
                                ones += smp[i] ? 1 : 0;
                            end
                            if (np == 1) ones += smp[nb] ? 1 : 0;
                            for (int i = nb + np; i < k; i++) if (!smp[i]) anystop0 = 1;
                            e_pe = (np == 1) && ((ones % 2) != (cfg_par_even ? 0 : 1));
                            e_fe = anystop0;
                            m_mode = 0;
                        end
                    end
                end
            end
            m_s2 = m_s1; m_s1 = rxd;
        end
    end

    // Compare the design with the model on every clock.
    bit prev_v = 0;
    always @(negedge clk) begin
        if (run_cmp) begin
            chk(rx_valid === e_valid, "R3 valid pulse", rx_valid, e_valid);
            chk(rx_data === e_data, "R3 data", rx_data, e_data);
            chk(rx_parity_err === e_pe, "R4 parity flag", rx_parity_err, e_pe);
            chk(rx_frame_err === e_fe, "R5 framing flag", rx_frame_err, e_fe);
            chk(rx_break === e_brk, "R6 break flag", rx_break, e_brk);
            chk(rts_n === e_rts, "R7 rts_n", rts_n, e_rts);
            chk(!(rx_valid && prev_v), "R9 valid single cycle", 1, 0);
            prev_v = rx_valid;
            if (rx_valid) n_valid++;
            if (rx_break) n_brk++;
            if (rx_frame_err) n_fe++;
            if (rx_parity_err) n_pe++;
        end
    end

    task automatic bit_time(input bit v);
        rxd = v;
        repeat (16 * div) @(negedge clk);
    endtask

    // Send a frame in the current format; flip_par inverts parity,
    // low_stop selects which stop bit (1 or 2) is driven low.
    task automatic send(input logic [7:0] d, input bit flip_par, input int low_stop);
        int nb; bit p;
        nb = int'(cfg_bits) + 1;
        p = 0;
        bit_time(0);
        for (int i = 0; i < nb; i++) begin bit_time(d[i]); p ^= d[i]; end
        if (cfg_par_en) bit_time((cfg_par_even ? p : ~p) ^ flip_par);
        bit_time(low_stop == 1 ? 1'b0 : 1'b1);
        if (cfg_two_stop) bit_time(low_stop == 2 ? 1'b0 : 1'b1);
        bit_time(1); bit_time(1);
    endtask

    task automatic fmt(input logic [2:0] b, input bit pe, input bit ev, input bit ts);
        cfg_bits = b; cfg_par_en = pe; cfg_par_even = ev; cfg_two_stop = ts;
    endtask

    initial begin
        int v0, b0, f0, p0;
        @(negedge clk);
        rxd = 1'b0; cfg_hs_en = 1; sink_full = 1;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(rx_valid == 0 && rx_break == 0 && rx_frame_err == 0 && rx_parity_err == 0,
            "R1 pulses low in reset", int'(rx_valid | rx_break | rx_frame_err | rx_parity_err), 0);
        chk(rx_data == 0, "R1 data cleared", rx_data, 0);
        chk(rts_n == 0, "R1 rts_n low in reset", rts_n, 0);
        rxd = 1'b1; cfg_hs_en = 0; sink_full = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; run_cmp = 1;
        repeat (40) @(negedge clk);

        // R3: 8N1 frames.
        v0 = n_valid;
        fmt(3'd7, 0, 0, 0);
        send(8'h55, 0, 0); send(8'hA3, 0, 0); send(8'hFF, 0, 0);
        chk(n_valid - v0 == 3, "R3 three 8-bit frames", n_valid - v0, 3);
        // R3: 1-bit word.
        v0 = n_valid;
        fmt(3'd0, 0, 0, 0);
        send(8'h01, 0, 0);
        chk(n_valid - v0 == 1 && rx_data == 8'h01, "R3 one-bit word", rx_data, 1);

        // R4: parity in both senses, then an injected fault.
        p0 = n_pe; v0 = n_valid;
        fmt(3'd6, 1, 1, 0); send(8'h35, 0, 0);
        fmt(3'd4, 1, 0, 0); send(8'h16, 0, 0);
        chk(n_pe - p0 == 0 && n_valid - v0 == 2, "R4 good parity", n_pe - p0, 0);
        p0 = n_pe;
        fmt(3'd7, 1, 1, 0); send(8'h5A, 1, 0);
        chk(n_pe - p0 == 1, "R4 bad parity flagged", n_pe - p0, 1);

        // R5: stop faults in one- and two-stop modes; data still delivered.
        f0 = n_fe; v0 = n_valid;
        fmt(3'd7, 0, 0, 1); send(8'h3C, 0, 2);
        chk(n_fe - f0 == 1 && rx_data == 8'h3C, "R5 second stop low", rx_data, 8'h3C);
        fmt(3'd7, 0, 0, 0); send(8'hC3, 0, 1);
        chk(n_fe - f0 == 2 && n_valid - v0 == 2, "R5 first stop low", n_fe - f0, 2);
        fmt(3'd7, 0, 0, 1); send(8'h81, 0, 0);

        // R6: break with parity, then a normal frame.
        b0 = n_brk; v0 = n_valid;
        fmt(3'd7, 1, 1, 0);
        rxd = 0; repeat (16 * 14) @(negedge clk);
        rxd = 1; repeat (16 * 2) @(negedge clk);
        chk(n_brk - b0 == 1 && n_valid == v0, "R6 break without valid", n_brk - b0, 1);
        send(8'h42, 0, 0);
        chk(n_valid - v0 == 1 && rx_data == 8'h42, "R6 frame after break", rx_data, 8'h42);

        // R2: short low glitch rejected.
        v0 = n_valid; b0 = n_brk;
        rxd = 0; repeat (4) @(negedge clk);
        rxd = 1; repeat (16 * 12) @(negedge clk);
        chk(n_valid == v0 && n_brk == b0, "R2 glitch ignored", n_valid - v0, 0);

        // R8: slow tick, frames still recovered.
        div = 3; v0 = n_valid;
        fmt(3'd7, 1, 0, 1);
        send(8'h9E, 0, 0); send(8'h00, 0, 0);
        chk(n_valid - v0 == 2 && rx_data == 8'h00, "R8 slow tick frames", n_valid - v0, 2);
        div = 1;

        // R7: handshake.
        cfg_hs_en = 1; sink_full = 1; repeat (2) @(negedge clk);
        chk(rts_n == 1, "R7 rts raised", rts_n, 1);
        cfg_hs_en = 0; repeat (2) @(negedge clk);
        chk(rts_n == 0, "R7 disabled handshake", rts_n, 0);
        cfg_hs_en = 1; sink_full = 0; repeat (2) @(negedge clk);
        chk(rts_n == 0, "R7 sink not full", rts_n, 0);

        repeat (10) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule